// File: doc/BRIEF.md
# Eight-Channel DAC Register Controller

This block is the digital front end of an eight-channel, 12-bit digital-to-analog converter. A host shifts 16-bit frames into it over a three-wire serial link. Each frame holds a 4-bit address and 12 data bits. The address selects one of eight channel input registers, one of four pair registers, a preset register or one of two control registers. A pair write fills the first channel of the pair with a code and the second channel with the complement of that code. This gives differential outputs from a single frame.

The input registers are held until the load strobe rises. All eight converter codes are then updated together. If the preset request is held low when the strobe rises, every converter code takes the stored preset value instead. The data path can be built with 12, 10 or 8 significant bits, and it can take two's-complement input. The serial stream is echoed on a second output 16 clocks later, so that several devices can share one link in a chain. The power-down and speed settings are only driven out as control levels.

Top module: `octal_dac_ctrl`

## Requirements
- R1: A frame is 16 bits, sent MSB first. Each bit is sampled on a rising `clk` edge while `fs_n` is low. Bits 15..12 are the address and bits 11..0 are the data. The frame is acted on at the edge that samples its 16th bit. Any further bits sampled before `fs_n` goes high are ignored.
- R2: A write to address 0..7 loads channel input register A..H with the converted code. The converter output only shows it after the next load.
- R3: A write to address 8, 9, 10 or 11 (pairs AB, CD, EF, GH) loads the first channel of the pair with the converted code. It loads the second channel with the bitwise complement of that code, taken over the active resolution.
- R4: With parameter `RES` at 12, 10 or 8, the data bits below the top `RES` bits are stored as zero. So at 10 bits, D1..D0 are cleared, and at 8 bits, D3..D0 are cleared.
- R5: When control register 0 bit 0 is 1, incoming codes are read as two's complement. Bit 11 of the code is inverted before it is stored, which gives offset binary. When the bit is 0, codes are stored as straight binary.
- R6: A rising edge on `ldac` copies all eight input registers to the converter codes at once. The codes change at the second rising `clk` edge after the edge that first samples `ldac` high, and they hold between loads.
- R7: Address 12 writes the preset register, which resets to zero. If `pre_n` is low when a load occurs, all eight converter codes take the preset value, and the input registers are left as they were. `pre_n` passes through the same two-stage synchronizer as `ldac`.
- R8: Control register 0 (address 13) bit 4 drives `pd_all` and bit 3 enables the echo output. Control register 1 (address 14) bits 7..4 drive `pair_pd[3:0]`, and bits 3..0 drive `pair_fast[3:0]`. In both vectors, index 0 is pair AB and index 3 is pair GH. All other control bits are ignored.
- R9: While echo is enabled, the value on `dout` just after clock edge n equals `din` as sampled at edge n-15, so a downstream device sees it 16 edges after it was sampled. While echo is disabled, `dout` is low.
- R10: A frame that `fs_n` ends before its 16th bit changes no register.
- R11: After reset, every converter code, `pd_all`, `pair_pd`, `pair_fast` and `dout` are zero.
- R12: Address 15 is a no-operation and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock and block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 1 | Serial data in |
| fs_n | input | 1 | Active-low frame enable |
| ldac | input | 1 | Load strobe; rising edge updates converter codes |
| pre_n | input | 1 | Active-low preset request, asynchronous |
| dout | output | 1 | Serial echo, 16 clocks late |
| dac_code | output | 96 | Eight 12-bit converter codes, channel A in bits 11..0 |
| pd_all | output | 1 | Whole-device power-down level |
| pair_pd | output | 4 | Per-pair power-down levels, index 0 = AB |
| pair_fast | output | 4 | Per-pair fast-settling levels, index 0 = AB |

## Verification
The write path is tried on single channels, on pairs whose data has mixed bit patterns, on all-ones data and on the two's-complement extremes. This tells complement errors apart from conversion errors. A copy of the block built at 10 bits runs on the same stimulus, which exposes masking mistakes that the 12-bit copy cannot show. Loads are given with the preset request both low and high, which separates a preset override from an ordinary copy. Truncated frames, overlong frames and no-op frames check that nothing is written by mistake, and single isolated pulses on the serial input pin down the echo delay to the exact cycle.

// File: rtl/octdac_pkg.sv
package octdac_pkg;
  localparam int unsigned WORD_W    = 16;
  localparam int unsigned ADDR_W    = 4;
  localparam int unsigned DATA_W    = 12;
  localparam int unsigned NCH       = 8;
  localparam int unsigned NPAIR     = NCH / 2;
  localparam int unsigned PAIR_BASE = NCH;
  localparam int unsigned ECHO_LAG  = WORD_W;

  localparam logic [ADDR_W-1:0] ADDR_PRESET = ADDR_W'(12);
  localparam logic [ADDR_W-1:0] ADDR_CTRL0  = ADDR_W'(13);
  localparam logic [ADDR_W-1:0] ADDR_CTRL1  = ADDR_W'(14);

  localparam int unsigned C0_PD_BIT   = 4;
  localparam int unsigned C0_ECHO_BIT = 3;
  localparam int unsigned C0_TWOS_BIT = 0;

  typedef logic [DATA_W-1:0] code_t;

  // Keeps the top res bits of a code
  function automatic code_t res_mask(input int unsigned res);
    code_t m;
    m = '1;
    m = m << (DATA_W - res);
    return m;
  endfunction

  // Masks to resolution, then maps two's complement to offset binary
  function automatic code_t to_offset(input code_t raw, input logic twos,
                                      input int unsigned res);
    code_t c;
    c = raw & res_mask(res);
    if (twos) c[DATA_W-1] = ~c[DATA_W-1];
    return c;
  endfunction

  // Complement inside the active resolution
  function automatic code_t partner(input code_t c, input int unsigned res);
    return ~c & res_mask(res);
  endfunction
endpackage

// File: rtl/octdac_sync.sv
module octdac_sync #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);
  logic meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta  <= RST_VAL;
      q_out <= RST_VAL;
    end else begin
      meta  <= d_in;
      q_out <= meta;
    end
  end
endmodule

// File: rtl/octdac_frame_rx.sv
module octdac_frame_rx #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              din,
  input  logic              fs_n,
  output logic              frame_fire,
  output logic [WORD_W-1:0] frame_word
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  logic [WORD_W-2:0] shreg;
  logic [CNT_W-1:0]  bit_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else if (fs_n) begin
      bit_cnt <= '0;
    end else if (bit_cnt != FULL) begin
      shreg   <= {shreg[WORD_W-3:0], din};
      bit_cnt <= bit_cnt + 1'b1;
    end
  end

  assign frame_fire = !fs_n && (bit_cnt == LAST);
  assign frame_word = {shreg, din};
endmodule

// File: rtl/octdac_echo.sv
module octdac_echo #(
  parameter int unsigned DEPTH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic tap
);
  logic [DEPTH-1:0] line;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line <= '0;
    else        line <= {line[DEPTH-2:0], din};
  end
  assign tap = line[DEPTH-1];
endmodule

// File: rtl/octal_dac_ctrl.sv
module octal_dac_ctrl import octdac_pkg::*; #(
  parameter int unsigned RES = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   din,
  input  logic                   fs_n,
  input  logic                   ldac,
  input  logic                   pre_n,
  output logic                   dout,
  output logic [NCH*DATA_W-1:0]  dac_code,
  output logic                   pd_all,
  output logic [NPAIR-1:0]       pair_pd,
  output logic [NPAIR-1:0]       pair_fast
);
  logic              frame_fire;
  logic [WORD_W-1:0] frame_word;
  logic [ADDR_W-1:0] frame_addr;
  code_t             frame_data, conv_code, comp_code;

  logic ldac_s, ldac_d, pre_s, load_evt, echo_tap;
  logic twos_q, echo_en_q, pd_q;
  logic [2*NPAIR-1:0] ctrl1_q;
  code_t preset_q;
  code_t in_q  [NCH];
  code_t dac_q [NCH];
  logic [NCH-1:0] ch_wr;
  code_t ch_wdata [NCH];
  logic [NCH*DATA_W-1:0] in_flat;

  octdac_frame_rx #(.WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .din(din), .fs_n(fs_n),
    .frame_fire(frame_fire), .frame_word(frame_word)
  );

  octdac_sync #(.RST_VAL(1'b0)) u_sync_ldac (
    .clk(clk), .rst_n(rst_n), .d_in(ldac), .q_out(ldac_s)
  );
  octdac_sync #(.RST_VAL(1'b1)) u_sync_pre (
    .clk(clk), .rst_n(rst_n), .d_in(pre_n), .q_out(pre_s)
  );

  octdac_echo #(.DEPTH(ECHO_LAG)) u_echo (
    .clk(clk), .rst_n(rst_n), .din(din), .tap(echo_tap)
  );

  assign frame_addr = frame_word[WORD_W-1 -: ADDR_W];
  assign frame_data = frame_word[DATA_W-1:0];
  assign conv_code  = to_offset(frame_data, twos_q, RES);
  assign comp_code  = partner(conv_code, RES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ldac_d <= 1'b0;
    else        ldac_d <= ldac_s;
  end
  assign load_evt = ldac_s & ~ldac_d;

  // Per-channel write decode: own address, or the pair address
  for (genvar g = 0; g < NCH; g++) begin : g_wr
    assign ch_wr[g] = frame_fire &&
                      ((frame_addr == ADDR_W'(g)) ||
                       (frame_addr == ADDR_W'(PAIR_BASE + g / 2)));
    if ((g % 2) == 0) begin : g_first
      assign ch_wdata[g] = conv_code;
    end else begin : g_second
      assign ch_wdata[g] = (frame_addr == ADDR_W'(g)) ? conv_code : comp_code;
    end
    assign in_flat[g*DATA_W +: DATA_W]  = in_q[g];
    assign dac_code[g*DATA_W +: DATA_W] = dac_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int ch = 0; ch < NCH; ch++) in_q[ch] <= '0;
    end else begin
      for (int ch = 0; ch < NCH; ch++)
        if (ch_wr[ch]) in_q[ch] <= ch_wdata[ch];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preset_q  <= '0;
      twos_q    <= 1'b0;
      echo_en_q <= 1'b0;
      pd_q      <= 1'b0;
      ctrl1_q   <= '0;
    end else if (frame_fire) begin
      case (frame_addr)
        ADDR_PRESET: preset_q <= conv_code;
        ADDR_CTRL0: begin
          pd_q      <= frame_data[C0_PD_BIT];
          echo_en_q <= frame_data[C0_ECHO_BIT];
          twos_q    <= frame_data[C0_TWOS_BIT];
        end
        ADDR_CTRL1: ctrl1_q <= frame_data[2*NPAIR-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int ch = 0; ch < NCH; ch++) dac_q[ch] <= '0;
    end else if (load_evt) begin
      for (int ch = 0; ch < NCH; ch++)
        dac_q[ch] <= pre_s ? in_q[ch] : preset_q;
    end
  end

  assign dout      = echo_en_q & echo_tap;
  assign pd_all    = pd_q;
  assign pair_pd   = ctrl1_q[2*NPAIR-1:NPAIR];
  assign pair_fast = ctrl1_q[NPAIR-1:0];
endmodule

// File: rtl/octdac_checker.sv
module octdac_checker import octdac_pkg::*; #(
  parameter int unsigned RES = 12
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  din,
  input logic                  dout,
  input logic                  echo_en,
  input logic                  frame_fire,
  input logic [ADDR_W-1:0]     frame_addr,
  input logic                  load_evt,
  input logic                  pre_ok,
  input logic [NCH*DATA_W-1:0] in_flat,
  input code_t                 preset,
  input logic [NCH*DATA_W-1:0] dac_code
);
  localparam code_t MASK = res_mask(RES);

  initial begin
    a_res_legal_r4: assert (RES == 12 || RES == 10 || RES == 8)
      else $error("RES must be 12, 10 or 8");
  end

  logic [4:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           age <= '0;
    else if (age != 5'd31) age <= age + 1'b1;
  end

  p_echo_delay_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 5'd16 && echo_en) |-> (dout == $past(din, 16)));

  p_load_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && pre_ok) |=> (dac_code == $past(in_flat)));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(dac_code));

  p_preset_force_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !pre_ok) |=> (dac_code == {NCH{$past(preset)}}));

  p_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_fire |=> $stable(in_flat));

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    p_pair_comp_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_fire && frame_addr == ADDR_W'(PAIR_BASE + p)) |=>
      ((in_flat[2*p*DATA_W +: DATA_W] ^ in_flat[(2*p+1)*DATA_W +: DATA_W]) == MASK));
  end

  for (genvar c = 0; c < NCH; c++) begin : g_mask
    p_res_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((dac_code[c*DATA_W +: DATA_W] & ~MASK) == '0));
  end
endmodule

bind octal_dac_ctrl octdac_checker #(.RES(RES)) u_chk (
  .clk(clk), .rst_n(rst_n), .din(din), .dout(dout), .echo_en(echo_en_q),
  .frame_fire(frame_fire), .frame_addr(frame_addr), .load_evt(load_evt),
  .pre_ok(pre_s), .in_flat(in_flat), .preset(preset_q), .dac_code(dac_code)
);

// File: tb/octal_dac_ctrl_bench.sv
module octal_dac_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0, din = 1'b0, fs_n = 1'b1, ldac = 1'b0, pre_n = 1'b1;
  logic dout, dout10, pd_all, pd_all10;
  logic [95:0] dac_code, dac_code10;
  logic [3:0] pair_pd, pair_fast, pair_pd10, pair_fast10;

  int checks = 0, failures = 0;
  bit started = 0, done = 0;
  string cur_req = "R11";

  always #2 clk = ~clk;

  octal_dac_ctrl #(.RES(12)) u_octal_dac_ctrl (
    .clk(clk), .rst_n(rst_n), .din(din), .fs_n(fs_n), .ldac(ldac), .pre_n(pre_n),
    .dout(dout), .dac_code(dac_code), .pd_all(pd_all),
    .pair_pd(pair_pd), .pair_fast(pair_fast));

  octal_dac_ctrl #(.RES(10)) u_octal_dac_ctrl_r10 (
    .clk(clk), .rst_n(rst_n), .din(din), .fs_n(fs_n), .ldac(ldac), .pre_n(pre_n),
    .dout(dout10), .dac_code(dac_code10), .pd_all(pd_all10),
    .pair_pd(pair_pd10), .pair_fast(pair_fast10));

  // ---------------- reference model (12-bit instance) ----------------
  int m_in [8];
  int m_dac [8];
  int m_preset, m_ctrl1, fcnt, fword;
  bit m_twos, m_echo, m_pd;
  bit lh[$], ph[$], dh[$];

  function automatic int offset_of(int d, bit twos);
    int v;
    if (!twos) return d;
    v = (d >= 2048) ? d - 4096 : d;
    return v + 2048;
  endfunction

  task automatic model_apply(int w);
    int a, d, code;
    a = w / 4096;
    d = w % 4096;
    code = offset_of(d, m_twos);
    if (a < 8) m_in[a] = code;
    else if (a < 12) begin
      m_in[2*(a-8)]   = code;
      m_in[2*(a-8)+1] = 4095 - code;
    end else if (a == 12) m_preset = code;
    else if (a == 13) begin
      m_pd = d[4]; m_echo = d[3]; m_twos = d[0];
    end else if (a == 14) m_ctrl1 = d % 256;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin m_in[i] = 0; m_dac[i] = 0; end
      m_preset = 0; m_ctrl1 = 0; m_twos = 0; m_echo = 0; m_pd = 0;
      fcnt = 0; fword = 0;
      lh = '{0, 0, 0}; ph = '{1, 1, 1};
      dh.delete();
      for (int i = 0; i < 15; i++) dh.push_back(1'b0);
      started = 1;
    end else begin
      lh.push_back(ldac); ph.push_back(pre_n); dh.push_back(din);
      if (lh.size() > 4) void'(lh.pop_front());
      if (ph.size() > 4) void'(ph.pop_front());
      if (dh.size() > 16) void'(dh.pop_front());
      if (lh[1] && !lh[0])
        for (int i = 0; i < 8; i++) m_dac[i] = ph[1] ? m_in[i] : m_preset;
      if (fs_n) fcnt = 0;
      else if (fcnt < 16) begin
        fword = (fword * 2 + din) % 65536;
        fcnt++;
        if (fcnt == 16) model_apply(fword);
      end
    end
  end

  task automatic chk(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s %s got %h expected %h", req, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      for (int i = 0; i < 8; i++)
        chk(cur_req, $sformatf("model dac ch%0d", i), int'(dac_code[i*12 +: 12]), m_dac[i]);
      chk(cur_req, "model dout", int'(dout), m_echo ? int'(dh[0]) : 0);
      chk(cur_req, "model pd_all", int'(pd_all), int'(m_pd));
      chk(cur_req, "model pair_pd", int'(pair_pd), m_ctrl1 / 16);
      chk(cur_req, "model pair_fast", int'(pair_fast), m_ctrl1 % 16);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic send(input logic [15:0] w, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      fs_n = 1'b0;
      din  = (i < 16) ? w[15-i] : 1'b1;
    end
    @(negedge clk);
    fs_n = 1'b1; din = 1'b0;
  endtask

  task automatic load();
    @(negedge clk); ldac = 1'b1;
    repeat (3) @(negedge clk);
    ldac = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  function automatic int ch12(int c); return int'(dac_code[c*12 +: 12]); endfunction
  function automatic int ch10(int c); return int'(dac_code10[c*12 +: 12]); endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "reset dac", int'(|dac_code), 0);
    chk("R11", "reset dout/pd", int'({dout, pd_all, pair_pd, pair_fast}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 single channel write
    cur_req = "R2";
    send(16'h0ABC, 16);
    repeat (2) @(negedge clk);
    chk("R6", "no change before load", ch12(0), 0);
    cur_req = "R6";
    load();
    chk("R2", "chan A after load", ch12(0), 'hABC);

    // R3 pairs and R4 resolution
    cur_req = "R3";
    send(16'h8123, 16);
    send(16'h93C5, 16);
    send(16'h4FFF, 16);
    load();
    chk("R3", "pair AB first", ch12(0), 'h123);
    chk("R3", "pair AB second", ch12(1), 'hEDC);
    chk("R3", "pair CD first", ch12(2), 'h3C5);
    chk("R3", "pair CD second", ch12(3), 'hC3A);
    chk("R4", "r10 chan E", ch10(4), 'hFFC);
    chk("R4", "r10 pair A", ch10(0), 'h120);
    chk("R4", "r10 pair B", ch10(1), 'hEDC);
    chk("R4", "r12 chan E", ch12(4), 'hFFF);

    // R5 two's complement
    cur_req = "R5";
    send(16'hD001, 16);
    send(16'h77FF, 16);
    send(16'h5000, 16);
    send(16'h6800, 16);
    load();
    chk("R5", "twos max", ch12(7), 'hFFF);
    chk("R5", "twos zero", ch12(5), 'h800);
    chk("R5", "twos min", ch12(6), 'h000);
    chk("R5", "r10 twos max", ch10(7), 'hFFC);
    send(16'hD000, 16);

    // R7 preset
    cur_req = "R7";
    send(16'hC555, 16);
    @(negedge clk); pre_n = 1'b0;
    load();
    for (int i = 0; i < 8; i++) chk("R7", $sformatf("preset ch%0d", i), ch12(i), 'h555);
    chk("R7", "r10 preset", ch10(3), 'h554);
    pre_n = 1'b1;
    repeat (3) @(negedge clk);
    load();
    chk("R7", "inputs kept after preset", ch12(0), 'h123);

    // R10 abort, R1 overlong frame, R12 no-op
    cur_req = "R10";
    send(16'h0000, 10);
    cur_req = "R1";
    send(16'h10F0, 20);
    cur_req = "R12";
    send(16'hF123, 16);
    load();
    chk("R10", "aborted frame ignored", ch12(0), 'h123);
    chk("R1", "overlong frame first 16 bits", ch12(1), 'h0F0);
    chk("R12", "no-op leaves chan C", ch12(2), 'h3C5);
    chk("R12", "no-op leaves chan H", ch12(7), 'hFFF);

    // R8 control outputs
    cur_req = "R8";
    send(16'hE0A5, 16);
    send(16'hD010, 16);
    @(negedge clk);
    chk("R8", "pair_pd", int'(pair_pd), 'hA);
    chk("R8", "pair_fast", int'(pair_fast), 'h5);
    chk("R8", "pd_all", int'(pd_all), 1);

    // R9 echo delay
    cur_req = "R9";
    send(16'hD018, 16);
    repeat (20) @(negedge clk);
    din = 1'b1;
    @(negedge clk); din = 1'b0;
    repeat (14) @(negedge clk);
    chk("R9", "echo not early", int'(dout), 0);
    @(negedge clk);
    chk("R9", "echo at lag", int'(dout), 1);
    @(negedge clk);
    chk("R9", "echo single pulse", int'(dout), 0);
    send(16'hD010, 16);
    din = 1'b1;
    repeat (20) @(negedge clk);
    chk("R9", "echo disabled low", int'(dout), 0);
    din = 1'b0;
    repeat (4) @(negedge clk);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule